// File: doc/BRIEF.md
# Multicycle Shared-Memory CPU Datapath

This block is the datapath of a 32-bit load/store processor that takes several clock cycles for each instruction. One unified memory holds both the program and the data. One ALU computes the next sequential PC as well as the instruction results. An external sequencer drives the datapath. Each cycle it sets the strobes and select lines, reads back the opcode, function field and zero flag, and picks its next step.

The datapath holds the PC and the instruction register. Between steps it keeps intermediate values in a memory data register, two operand latches and an ALU result register. These latches let a later cycle reuse a value computed earlier. A typical sequence is: fetch while adding 4 to the PC, decode while computing a branch target, execute, then either access memory or write back. A conditional branch writes the PC only when the ALU result is zero. The memory has 256 words and is word-addressed. Reads are combinational and writes take effect at the clock edge.

Top module: `mc_datapath`

## Requirements
- R1: With `rst` high at a clock edge, the PC, instruction register and ALU result register become zero, so `pc_o`, `opcode`, `funct` and `alu_out_o` all read zero.
- R2: The memory address is the PC when `addr_sel` is 0 and the ALU result register when `addr_sel` is 1. Address bits [9:2] select the word.
- R3: The instruction register loads the memory word only at an edge where `ir_wr` is 1 and holds otherwise. `opcode` is instruction bits [31:26] and `funct` is bits [5:0]. Fields rs=[25:21], rt=[20:16], rd=[15:11], immediate=[15:0] and target=[25:0].
- R4: The PC is written at an edge where `pc_wr` is 1, or where `pc_wr_cond` is 1 and `zero` is 1. In every other cycle it holds.
- R5: The 16-bit immediate is zero-extended when `imm_zext` is 1 and sign-extended when it is 0.
- R6: With `pc_src`=1 the PC takes the ALU result register. During decode this register is loaded with PC+4 plus the sign-extended immediate times four. With `pc_src`=0 the PC takes the live ALU result.
- R7: With `pc_src`=2 the PC takes bits [31:28] of the already-incremented PC, then the 26-bit target field, then two zero bits.
- R8: The write destination is rd when `reg_dst` is 1 and rt when it is 0. The write data is the memory data register when `mem_to_reg` is 1 and the ALU result register when it is 0.
- R9: ALU operand A is the PC when `alu_src_a` is 0 and latch A when it is 1. Operand B is selected by `alu_src_b`: 0 = latch B, 1 = constant 4, 2 = extended immediate, 3 = extended immediate shifted left by 2.
- R10: Register 0 reads as zero, and writes to it have no effect.
- R11: `alu_fn` selects the ALU operation: 000 AND, 001 OR, 010 add, 110 subtract, 111 signed set-less-than. `zero` is 1 exactly when the live ALU result is all zeros.
- R12: A store writes latch B into memory at the clock edge. A later read of the same address returns the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_wr | input | 1 | Unconditional PC write |
| pc_wr_cond | input | 1 | PC write qualified by the zero flag |
| addr_sel | input | 1 | Memory address select: 0 PC, 1 ALU result register |
| mem_wr | input | 1 | Memory write strobe |
| ir_wr | input | 1 | Instruction register load |
| reg_dst | input | 1 | Destination select: 0 rt, 1 rd |
| reg_wr | input | 1 | Register file write strobe |
| mem_to_reg | input | 1 | Write data select: 0 ALU result register, 1 memory data register |
| alu_src_a | input | 1 | Operand A select: 0 PC, 1 latch A |
| alu_src_b | input | 2 | Operand B select |
| alu_fn | input | 3 | ALU operation |
| imm_zext | input | 1 | 1 zero-extends the immediate, 0 sign-extends it |
| pc_src | input | 2 | Next-PC source |
| opcode | output | 6 | Instruction bits [31:26] |
| funct | output | 6 | Instruction bits [5:0] |
| zero | output | 1 | Live ALU result is zero |
| pc_o | output | 32 | Current PC |
| alu_out_o | output | 32 | ALU result register |

## Verification
In the fetch cycle the memory read and the PC increment happen together. The instruction register must capture the word at the old PC while the PC moves to PC+4, and the bench checks both `opcode` and `pc_o` after that edge. The conditional branch is the tighter case: in one cycle the ALU subtracts the two operand latches and the PC write is gated by the resulting zero flag. The bench runs a branch whose operands differ and one whose operands are equal. For each it checks `zero` in mid-cycle and then checks `pc_o` after the edge against a fall-through address or a target computed independently.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_fn_e;

  typedef enum logic [1:0] {
    OPB_REG    = 2'd0,
    OPB_FOUR   = 2'd1,
    OPB_IMM    = 2'd2,
    OPB_IMM_SH = 2'd3
  } opb_sel_e;

  typedef enum logic [1:0] {
    PCN_ALU    = 2'd0,
    PCN_ALUREG = 2'd1,
    PCN_JUMP   = 2'd2
  } pcn_sel_e;

  localparam int INSN_W = 32;
  localparam int IMM_W  = 16;
  localparam int TGT_W  = 26;
  localparam int FLD_W  = 6;

endpackage

// File: rtl/mcd_alu.sv
module mcd_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   fn,
  output logic [W-1:0] y,
  output logic         zero
);
  import mcd_pkg::*;

  logic [W-1:0] sum;
  logic [W-1:0] diff;
  logic         lt;

  assign sum  = a + b;
  assign diff = a - b;
  assign lt   = $signed(a) < $signed(b);

  always_comb begin
    case (alu_fn_e'(fn))
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = sum;
      ALU_SUB: y = diff;
      ALU_SLT: y = {{(W-1){1'b0}}, lt};
      default: y = sum;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/mcd_regfile.sv
module mcd_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] regs_q [N];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs_q[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs_q[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs_q[raddr_b];
endmodule

// File: rtl/mcd_mem.sv
module mcd_mem #(
  parameter int W     = 32,
  parameter int WORDS = 256,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/mcd_immext.sv
module mcd_immext #(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic [IMM_W-1:0] imm,
  input  logic             zext,
  output logic [W-1:0]     ext,
  output logic [W-1:0]     ext_sh
);
  logic fill;

  assign fill   = zext ? 1'b0 : imm[IMM_W-1];
  assign ext    = {{(W-IMM_W){fill}}, imm};
  assign ext_sh = {ext[W-3:0], 2'b00};
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath #(
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 256,
  parameter int NREGS     = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pc_wr,
  input  logic                pc_wr_cond,
  input  logic                addr_sel,
  input  logic                mem_wr,
  input  logic                ir_wr,
  input  logic                reg_dst,
  input  logic                reg_wr,
  input  logic                mem_to_reg,
  input  logic                alu_src_a,
  input  logic [1:0]          alu_src_b,
  input  logic [2:0]          alu_fn,
  input  logic                imm_zext,
  input  logic [1:0]          pc_src,
  output logic [5:0]          opcode,
  output logic [5:0]          funct,
  output logic                zero,
  output logic [DATA_W-1:0]   pc_o,
  output logic [DATA_W-1:0]   alu_out_o
);
  import mcd_pkg::*;

  localparam int MEM_AW = $clog2(MEM_WORDS);
  localparam int REG_AW = $clog2(NREGS);
  localparam int TOP_W  = DATA_W - TGT_W - 2;

  logic [DATA_W-1:0] pc_q, ir_q, mdr_q, a_q, b_q, alu_out_q;
  logic [DATA_W-1:0] pc_next, mem_rdata, rdata_a, rdata_b;
  logic [DATA_W-1:0] alu_a, alu_b, alu_y, imm_ext, imm_ext_sh, wb_data;
  logic [MEM_AW-1:0] mem_addr;
  logic [REG_AW-1:0] rs_idx, rt_idx, rd_idx, wr_idx;
  logic              pc_en;

  assign rs_idx = ir_q[25:21];
  assign rt_idx = ir_q[20:16];
  assign rd_idx = ir_q[15:11];

  // shared memory port: fetch address or data address
  assign mem_addr = addr_sel ? alu_out_q[MEM_AW+1:2] : pc_q[MEM_AW+1:2];

  mcd_mem #(.W(DATA_W), .WORDS(MEM_WORDS)) u_mem (
    .clk   (clk),
    .we    (mem_wr),
    .addr  (mem_addr),
    .wdata (b_q),
    .rdata (mem_rdata)
  );

  assign wr_idx  = reg_dst ? rd_idx : rt_idx;
  assign wb_data = mem_to_reg ? mdr_q : alu_out_q;

  mcd_regfile #(.W(DATA_W), .N(NREGS)) u_rf (
    .clk     (clk),
    .we      (reg_wr),
    .waddr   (wr_idx),
    .wdata   (wb_data),
    .raddr_a (rs_idx),
    .raddr_b (rt_idx),
    .rdata_a (rdata_a),
    .rdata_b (rdata_b)
  );

  mcd_immext #(.W(DATA_W), .IMM_W(IMM_W)) u_ext (
    .imm    (ir_q[IMM_W-1:0]),
    .zext   (imm_zext),
    .ext    (imm_ext),
    .ext_sh (imm_ext_sh)
  );

  assign alu_a = alu_src_a ? a_q : pc_q;

  always_comb begin
    case (opb_sel_e'(alu_src_b))
      OPB_REG:    alu_b = b_q;
      OPB_FOUR:   alu_b = DATA_W'(4);
      OPB_IMM:    alu_b = imm_ext;
      OPB_IMM_SH: alu_b = imm_ext_sh;
      default:    alu_b = b_q;
    endcase
  end

  mcd_alu #(.W(DATA_W)) u_alu (
    .a    (alu_a),
    .b    (alu_b),
    .fn   (alu_fn),
    .y    (alu_y),
    .zero (zero)
  );

  always_comb begin
    case (pcn_sel_e'(pc_src))
      PCN_ALU:    pc_next = alu_y;
      PCN_ALUREG: pc_next = alu_out_q;
      PCN_JUMP:   pc_next = {pc_q[DATA_W-1 -: TOP_W], ir_q[TGT_W-1:0], 2'b00};
      default:    pc_next = alu_y;
    endcase
  end

  assign pc_en = pc_wr | (pc_wr_cond & zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= '0;
      ir_q      <= '0;
      mdr_q     <= '0;
      a_q       <= '0;
      b_q       <= '0;
      alu_out_q <= '0;
    end else begin
      if (pc_en) pc_q <= pc_next;
      if (ir_wr) ir_q <= mem_rdata;
      mdr_q     <= mem_rdata;
      a_q       <= rdata_a;
      b_q       <= rdata_b;
      alu_out_q <= alu_y;
    end
  end

  assign opcode    = ir_q[31:26];
  assign funct     = ir_q[5:0];
  assign pc_o      = pc_q;
  assign alu_out_o = alu_out_q;
endmodule

// File: rtl/mcd_checker.sv
module mcd_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         pc_wr,
  input logic         pc_wr_cond,
  input logic         ir_wr,
  input logic         zero,
  input logic [W-1:0] pc_q,
  input logic [W-1:0] pc_next,
  input logic [W-1:0] ir_q,
  input logic [W-1:0] mem_rdata,
  input logic [W-1:0] rdata_a
);
  assert_pc_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!pc_wr && !(pc_wr_cond && zero)) |=> (pc_q == $past(pc_q)));

  assert_pc_load_R4: assert property (@(posedge clk) disable iff (rst)
    pc_wr |=> (pc_q == $past(pc_next)));

  assert_ir_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !ir_wr |=> (ir_q == $past(ir_q)));

  assert_ir_load_R3: assert property (@(posedge clk) disable iff (rst)
    ir_wr |=> (ir_q == $past(mem_rdata)));

  assert_r0_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (ir_q[25:21] == 5'd0) |-> (rdata_a == '0));
endmodule

bind mc_datapath mcd_checker #(.W(32)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pc_wr      (pc_wr),
  .pc_wr_cond (pc_wr_cond),
  .ir_wr      (ir_wr),
  .zero       (zero),
  .pc_q       (pc_q),
  .pc_next    (pc_next),
  .ir_q       (ir_q),
  .mem_rdata  (mem_rdata),
  .rdata_a    (rdata_a)
);

// File: tb/mc_datapath_tb.sv
module mc_datapath_tb;
  import mcd_pkg::*;

  localparam int K_PC = 0, K_OP = 1, K_FN = 2, K_AOUT = 3, K_ZERO = 4;

  typedef struct {
    string       req;
    int          kind;
    logic [31:0] exp;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pc_wr, pc_wr_cond, addr_sel, mem_wr, ir_wr, reg_dst, reg_wr;
  logic mem_to_reg, alu_src_a, imm_zext;
  logic [1:0] alu_src_b, pc_src;
  logic [2:0] alu_fn;
  logic [5:0] opcode, funct;
  logic zero;
  logic [31:0] pc_o, alu_out_o;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  logic [31:0] pc_m = 32'd0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mc_datapath u_dut (
    .clk(clk), .rst(rst), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
    .addr_sel(addr_sel), .mem_wr(mem_wr), .ir_wr(ir_wr), .reg_dst(reg_dst),
    .reg_wr(reg_wr), .mem_to_reg(mem_to_reg), .alu_src_a(alu_src_a),
    .alu_src_b(alu_src_b), .alu_fn(alu_fn), .imm_zext(imm_zext),
    .pc_src(pc_src), .opcode(opcode), .funct(funct), .zero(zero),
    .pc_o(pc_o), .alu_out_o(alu_out_o)
  );

  // monitor: compares queued expectations mid-cycle
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        K_PC:    act = pc_o;
        K_OP:    act = {26'd0, opcode};
        K_FN:    act = {26'd0, funct};
        K_AOUT:  act = alu_out_o;
        default: act = {31'd0, zero};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind %0d actual %h expected %h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_v(input string req, input int kind, input logic [31:0] v);
    item_t it;
    it.req = req; it.kind = kind; it.exp = v;
    q.push_back(it);
  endtask

  task automatic idle();
    pc_wr = 0; pc_wr_cond = 0; addr_sel = 0; mem_wr = 0; ir_wr = 0;
    reg_dst = 0; reg_wr = 0; mem_to_reg = 0; alu_src_a = 0; imm_zext = 0;
    alu_src_b = 2'd0; pc_src = 2'd0; alu_fn = ALU_ADD;
  endtask

  task automatic tick();
    @(posedge clk); #1; idle();
  endtask

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [2:0] fn_of(input logic [5:0] f);
    case (f)
      6'h22:   return ALU_SUB;
      6'h24:   return ALU_AND;
      6'h25:   return ALU_OR;
      6'h2A:   return ALU_SLT;
      default: return ALU_ADD;
    endcase
  endfunction

  // fetch + decode, shared by all instructions
  task automatic front(input logic [31:0] i);
    ir_wr = 1; alu_src_b = 2'd1; alu_fn = ALU_ADD; pc_src = 2'd0; pc_wr = 1;
    tick();
    pc_m = pc_m + 4;
    expect_v("R4", K_PC, pc_m);           // R9 const 4 on operand B
    expect_v("R3", K_OP, {26'd0, i[31:26]});
    expect_v("R3", K_FN, {26'd0, i[5:0]});
    alu_src_b = 2'd3; alu_fn = ALU_ADD;
    tick();
    expect_v("R6", K_AOUT, pc_m + {{14{i[15]}}, i[15:0], 2'b00});
    expect_v("R4", K_PC, pc_m);
  endtask

  task automatic run_r(input logic [31:0] i, input logic [31:0] res);
    front(i);
    alu_src_a = 1; alu_src_b = 2'd0; alu_fn = fn_of(i[5:0]);
    tick();
    expect_v("R11", K_AOUT, res);
    expect_v("R3", K_OP, {26'd0, i[31:26]});
    reg_wr = 1; reg_dst = 1;
    tick();
  endtask

  task automatic run_ori(input logic [31:0] i, input logic [31:0] res);
    front(i);
    alu_src_a = 1; alu_src_b = 2'd2; imm_zext = 1; alu_fn = ALU_OR;
    tick();
    expect_v("R5", K_AOUT, res);
    reg_wr = 1; reg_dst = 0;
    tick();
  endtask

  task automatic run_lw(input logic [31:0] i, input logic [31:0] addr);
    front(i);
    alu_src_a = 1; alu_src_b = 2'd2; alu_fn = ALU_ADD;
    tick();
    expect_v("R5", K_AOUT, addr);
    addr_sel = 1;
    tick();
    expect_v("R2", K_PC, pc_m);
    reg_wr = 1; reg_dst = 0; mem_to_reg = 1;
    tick();
  endtask

  task automatic run_sw(input logic [31:0] i, input logic [31:0] addr);
    front(i);
    alu_src_a = 1; alu_src_b = 2'd2; alu_fn = ALU_ADD;
    tick();
    expect_v("R5", K_AOUT, addr);
    addr_sel = 1; mem_wr = 1;
    tick();
  endtask

  task automatic run_beq(input logic [31:0] i, input logic z, input logic [31:0] npc);
    front(i);
    alu_src_a = 1; alu_src_b = 2'd0; alu_fn = ALU_SUB; pc_wr_cond = 1; pc_src = 2'd1;
    expect_v("R11", K_ZERO, {31'd0, z});
    tick();
    pc_m = npc;
    expect_v("R4", K_PC, npc);
  endtask

  task automatic run_j(input logic [31:0] i);
    front(i);
    pc_wr = 1; pc_src = 2'd2;
    tick();
    pc_m = {pc_m[31:28], i[25:0], 2'b00};
    expect_v("R7", K_PC, pc_m);
  endtask

  initial begin
    idle();
    for (int k = 0; k < 256; k++) u_dut.u_mem.mem_q[k] = 32'd0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    expect_v("R1", K_PC, 32'd0);
    expect_v("R1", K_OP, 32'd0);
    expect_v("R1", K_FN, 32'd0);
    expect_v("R1", K_AOUT, 32'd0);

    run_ori(enc_i(6'h0D, 0, 1, 16'h8005), 32'h0000_8005);           // R5 zero-extend
    run_ori(enc_i(6'h0D, 0, 2, 16'h0003), 32'h0000_0003);
    run_r(enc_r(1, 2, 3, 6'h20), 32'h0000_8008);                     // R11 add
    run_r(enc_r(2, 1, 4, 6'h22), 32'hFFFF_7FFE);                     // R11 sub
    run_r(enc_r(4, 2, 5, 6'h2A), 32'd1);                             // R11 slt signed
    run_r(enc_r(2, 4, 6, 6'h2A), 32'd0);
    run_r(enc_r(1, 2, 6, 6'h24), 32'd1);                             // R11 and
    run_sw(enc_i(6'h2B, 0, 3, 16'h0200), 32'h200);                   // R12 store
    run_lw(enc_i(6'h23, 0, 7, 16'h0200), 32'h200);                   // R2 data address
    run_ori(enc_i(6'h0D, 0, 9, 16'h0204), 32'h204);
    run_lw(enc_i(6'h23, 9, 8, 16'hFFFC), 32'h200);                   // R5 sign-extend
    run_r(enc_r(1, 2, 0, 6'h20), 32'h0000_8008);                     // R10 write to r0
    run_r(enc_r(0, 0, 10, 6'h25), 32'd0);                            // R10 r0 reads zero
    run_r(enc_r(7, 8, 11, 6'h20), 32'h0001_0010);                    // R8 R12 loaded values
    run_beq(enc_i(6'h04, 1, 2, 16'd5), 1'b0, 32'd60);               // R4 not taken
    run_beq(enc_i(6'h04, 7, 8, 16'd2), 1'b1, 32'd72);               // R6 taken
    run_j({6'h02, 26'd32});                                          // R7 jump to 0x80
    run_r(enc_r(3, 0, 12, 6'h25), 32'h0000_8008);                    // R8 rd destination
    tick();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    u_dut.u_mem.mem_q[0]  = 32'd0;
    #1;
    u_dut.u_mem.mem_q[0]  = enc_i(6'h0D, 0, 1, 16'h8005);
    u_dut.u_mem.mem_q[1]  = enc_i(6'h0D, 0, 2, 16'h0003);
    u_dut.u_mem.mem_q[2]  = enc_r(1, 2, 3, 6'h20);
    u_dut.u_mem.mem_q[3]  = enc_r(2, 1, 4, 6'h22);
    u_dut.u_mem.mem_q[4]  = enc_r(4, 2, 5, 6'h2A);
    u_dut.u_mem.mem_q[5]  = enc_r(2, 4, 6, 6'h2A);
    u_dut.u_mem.mem_q[6]  = enc_r(1, 2, 6, 6'h24);
    u_dut.u_mem.mem_q[7]  = enc_i(6'h2B, 0, 3, 16'h0200);
    u_dut.u_mem.mem_q[8]  = enc_i(6'h23, 0, 7, 16'h0200);
    u_dut.u_mem.mem_q[9]  = enc_i(6'h0D, 0, 9, 16'h0204);
    u_dut.u_mem.mem_q[10] = enc_i(6'h23, 9, 8, 16'hFFFC);
    u_dut.u_mem.mem_q[11] = enc_r(1, 2, 0, 6'h20);
    u_dut.u_mem.mem_q[12] = enc_r(0, 0, 10, 6'h25);
    u_dut.u_mem.mem_q[13] = enc_r(7, 8, 11, 6'h20);
    u_dut.u_mem.mem_q[14] = enc_i(6'h04, 1, 2, 16'd5);
    u_dut.u_mem.mem_q[15] = enc_i(6'h04, 7, 8, 16'd2);
    u_dut.u_mem.mem_q[18] = {6'h02, 26'd32};
    u_dut.u_mem.mem_q[32] = enc_r(3, 0, 12, 6'h25);
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule